// File: doc/BRIEF.md
# Interrupting GPIO Bank

This block is one bank of general-purpose I/O pins with a word-addressed register port. Software drives pins through an output latch and an output-enable latch. It reads the pin levels back through a two-stage synchroniser. Each pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level.

Every control latch has three extra addresses: a set alias, a clear alias and a toggle alias. Software can therefore change the bit of one pin with a single write, without a read-modify-write. Detected events collect in sticky status bits. Software acknowledges them by writing ones to the clear alias of the status register. A single bank interrupt line combines every pending status bit whose pin is enabled.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every latch and status bit is zero, `pin_out` and `pin_oe` are zero, and `irq` is low.
- R2: `bus_addr[4:2]` selects the register: 0 output latch, 1 output enable, 2 pin levels (read-only), 3 interrupt routing, 4 interrupt enable, 5 trigger kind, 6 trigger sense, 7 status. `bus_addr[1:0]` selects the write operation for control registers: 0 load, 1 OR in, 2 AND-NOT out, 3 XOR. A read returns the register whatever the operation bits are.
- R3: `pin_out` equals the output latch and `pin_oe` equals the output-enable latch, one cycle after the write edge. Neither changes without a write.
- R4: The pin-level register shows `pin_in` after two clock edges, and writes to it are ignored.
- R5: Bit n of trigger kind (K) and trigger sense (S) choose pin n's event: K=0,S=1 rising edge; K=0,S=0 falling edge; K=1,S=1 high level; K=1,S=0 low level. An edge is a change of the synchronised level from one cycle to the next. A status bit is set on the third edge after the pin change.
- R6: A status bit can become set only while its routing bit is 1, and an edge-set bit stays set until acknowledged.
- R7: For a level trigger the status bit is set again on every cycle the level is active, so an acknowledge during the level does not clear it.
- R8: Writing ones to word address 30 (status, operation 2) clears exactly those status bits. Writes to status at operations 0, 1 and 3 are ignored.
- R9: When an acknowledge and a new event hit the same bit on the same edge, the bit stays set.
- R10: `irq` is high exactly when some status bit is set whose interrupt-enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Word address: register[4:2], operation[1:0] |
| bus_wdata | input | NPINS | Write data, bit n for pin n |
| bus_rdata | output | NPINS | Read data of the addressed register |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch to the pads |
| pin_oe | output | NPINS | Output enable to the pads, 1 drives |
| irq | output | 1 | Combined bank interrupt |

## Verification
The bench builds the bank with its default width of 32 pins, so every status, trigger and routing bit of a full-size bank is exercised. Random 32-bit configurations cover all four trigger kinds on different pins in the same trial. With the full width, a partial acknowledge that splits the word into halves shows that unwritten bits survive. Directed timing of an acknowledge against the synchroniser delay puts the collision of an event and an acknowledge on one exact edge.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [2:0] SEL_DOUT = 3'd0, SEL_OE = 3'd1, SEL_LVLIN = 3'd2,
                         SEL_ROUTE = 3'd3, SEL_IEN = 3'd4, SEL_KIND = 3'd5,
                         SEL_SENSE = 3'd6, SEL_STAT = 3'd7;
  localparam logic [1:0] OP_CLR = 2'd2;

  logic [2:0]       sel;
  logic [1:0]       op;
  logic [NPINS-1:0] dout_q, oe_q, route_q, ien_q, kind_q, sense_q, stat_q;
  logic [NPINS-1:0] sync_q, din_q, prev_q;
  logic [NPINS-1:0] rise, fall, edge_hit, level_hit, evt, ack;

  assign sel = bus_addr[4:2];
  assign op  = bus_addr[1:0];

  function automatic logic [NPINS-1:0] upd(input logic [NPINS-1:0] cur,
                                           input logic [1:0] o,
                                           input logic [NPINS-1:0] d);
    case (o)
      2'd0:    return d;
      2'd1:    return cur | d;
      2'd2:    return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      route_q <= '0;
      ien_q   <= '0;
      kind_q  <= '0;
      sense_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DOUT:  dout_q  <= upd(dout_q, op, bus_wdata);
        SEL_OE:    oe_q    <= upd(oe_q, op, bus_wdata);
        SEL_ROUTE: route_q <= upd(route_q, op, bus_wdata);
        SEL_IEN:   ien_q   <= upd(ien_q, op, bus_wdata);
        SEL_KIND:  kind_q  <= upd(kind_q, op, bus_wdata);
        SEL_SENSE: sense_q <= upd(sense_q, op, bus_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      din_q  <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= pin_in;
      din_q  <= sync_q;
      prev_q <= din_q;
    end
  end

  assign rise      = din_q & ~prev_q;
  assign fall      = ~din_q & prev_q;
  assign edge_hit  = ~kind_q & ((sense_q & rise) | (~sense_q & fall));
  assign level_hit = kind_q & ~(din_q ^ sense_q);
  assign evt       = route_q & (edge_hit | level_hit);
  assign ack       = (bus_wr && sel == SEL_STAT && op == OP_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~ack) | evt;
  end

  always_comb begin
    case (sel)
      SEL_DOUT:  bus_rdata = dout_q;
      SEL_OE:    bus_rdata = oe_q;
      SEL_LVLIN: bus_rdata = din_q;
      SEL_ROUTE: bus_rdata = route_q;
      SEL_IEN:   bus_rdata = ien_q;
      SEL_KIND:  bus_rdata = kind_q;
      SEL_SENSE: bus_rdata = sense_q;
      default:   bus_rdata = stat_q;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;
  assign irq     = |(stat_q & ien_q);
endmodule

module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] route_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] evt
);
  assert_dout_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'd0) |=> pin_out == $past(bus_wdata));

  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_unrouted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(route_q)) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'd30) |=> ((stat_q & $past(bus_wdata & ~evt)) == '0));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q == '0) || (stat_q == '0)) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .route_q(route_q), .ien_q(ien_q), .stat_q(stat_q), .evt(evt)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPINS(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] apply(input logic [31:0] c, input logic [1:0] o, input logic [31:0] d);
    case (o)
      2'd0: return d;
      2'd1: return c | d;
      2'd2: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction

  function automatic logic [31:0] lvl_hits(input logic [31:0] v, input logic [31:0] k, input logic [31:0] s);
    return k & ~(v ^ s);
  endfunction

  function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n,
                                            input logic [31:0] k, input logic [31:0] s);
    return ~k & ((s & n & ~o) | (~s & o & ~n));
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ctl [8];
    logic [31:0] v, oldv, newv, k, s, rt, en, exp;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) ctl[i] = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      rd(5'(i * 4), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    for (int i = 0; i < 300; i++) begin
      int idx;
      logic [1:0] o;
      logic [31:0] d;
      case ($urandom_range(0, 5))
        0: idx = 0; 1: idx = 1; 2: idx = 3; 3: idx = 4; 4: idx = 5; default: idx = 6;
      endcase
      o = 2'($urandom_range(0, 3));
      d = $urandom;
      wr(5'(idx * 4) | 5'(o), d);
      ctl[idx] = apply(ctl[idx], o, d);
      chk("R3 pin_out", pin_out, ctl[0]);
      chk("R3 pin_oe", pin_oe, ctl[1]);
      rd(5'(idx * 4) | 5'($urandom_range(0, 3)), v);
      chk("R2 readback", v, ctl[idx]);
    end

    for (int i = 3; i < 7; i++) begin
      wr(5'(i * 4), 32'h0);
      ctl[i] = '0;
    end
    wr(5'd30, 32'hFFFF_FFFF);

    wr(5'd8, 32'hFFFF_FFFF);
    wr(5'd9, 32'hFFFF_FFFF);
    rd(5'd8, v);
    chk("R4 write to levels ignored", v, 32'h0);
    pin_in = 32'hA5A5_0F0F;
    cyc(1);
    rd(5'd8, v);
    chk("R4 one edge not yet visible", v, 32'h0);
    cyc(1);
    rd(5'd8, v);
    chk("R4 visible after two edges", v, 32'hA5A5_0F0F);

    for (int t = 0; t < 40; t++) begin
      wr(5'd12, 32'h0);
      oldv = $urandom;
      pin_in = oldv;
      cyc(4);
      k = $urandom; s = $urandom; rt = $urandom; en = (t % 5 == 0) ? 32'h0 : $urandom;
      wr(5'd20, k);
      wr(5'd24, s);
      wr(5'd16, en);
      wr(5'd30, 32'hFFFF_FFFF);
      wr(5'd12, rt);
      cyc(4);
      newv = $urandom;
      pin_in = newv;
      cyc(4);
      exp = rt & (lvl_hits(oldv, k, s) | lvl_hits(newv, k, s) | edge_hits(oldv, newv, k, s));
      rd(5'd28, v);
      chk("R5 R6 status after pin change", v, exp);
      chk("R10 irq", {31'h0, irq}, {31'h0, |(exp & en)});
      wr(5'd30, 32'hFFFF_FFFF);
      cyc(1);
      rd(5'd28, v);
      chk("R7 level bits reassert after ack", v, rt & lvl_hits(newv, k, s));
    end

    wr(5'd12, 32'h0);
    wr(5'd16, 32'h0);
    pin_in = 32'h0;
    cyc(4);
    wr(5'd20, 32'hFFFF_FFFF);
    wr(5'd24, 32'hFFFF_FFFF);
    wr(5'd30, 32'hFFFF_FFFF);
    pin_in = 32'hFFFF_FFFF;
    cyc(4);
    rd(5'd28, v);
    chk("R6 unrouted high level sets nothing", v, 32'h0);

    wr(5'd20, 32'h0);
    pin_in = 32'h0;
    cyc(4);
    wr(5'd12, 32'hFFFF_FFFF);
    pin_in = 32'hFFFF_FFFF;
    cyc(4);
    pin_in = 32'h0;
    cyc(4);
    rd(5'd28, v);
    chk("R6 rising edge sticky after pin falls", v, 32'hFFFF_FFFF);
    chk("R10 irq low with no enables", {31'h0, irq}, 32'h0);
    wr(5'd16, 32'h0001_0000);
    chk("R10 irq high with one enabled pending bit", {31'h0, irq}, 32'h1);
    wr(5'd30, 32'h0000_FFFF);
    rd(5'd28, v);
    chk("R8 partial ack", v, 32'hFFFF_0000);
    wr(5'd28, 32'h0);
    wr(5'd29, 32'h0000_FFFF);
    wr(5'd31, 32'hFFFF_FFFF);
    rd(5'd28, v);
    chk("R8 other status operations ignored", v, 32'hFFFF_0000);
    wr(5'd30, 32'hFFFF_FFFF);
    chk("R10 irq low after ack", {31'h0, irq}, 32'h0);

    wr(5'd12, 32'h1);
    wr(5'd30, 32'hFFFF_FFFF);
    pin_in = 32'h1;
    cyc(2);
    wr(5'd30, 32'h1);
    rd(5'd28, v);
    chk("R9 event beats same-edge ack", v, 32'h1);
    pin_in = 32'h0;
    cyc(4);
    wr(5'd30, 32'h1);
    pin_in = 32'h1;
    cyc(3);
    wr(5'd30, 32'h1);
    rd(5'd28, v);
    chk("R9 ack one edge later clears", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule